// File: doc/BRIEF.md
# EFM Channel-Clock Recovery Loop

This block rebuilds the channel bit clock from a single-bit EFM playback signal that arrives with no clock of its own. A fast oversampling clock, supplied by an earlier clock-multiplier stage, samples the input. A numerically controlled phase accumulator then produces one channel-clock enable per recovered bit period. A proportional phase path and an integrating frequency path steer the accumulator. Together they follow the slow drift in pulse widths that comes from changes in spindle speed. The frequency path can be switched off, which leaves only phase correction. In that mode the pull-in range is narrow.

At every input transition, the block reports how many whole channel periods have passed since the previous transition. It raises a violation flag when that count falls outside the legal 3 to 11 range. A lock flag comes from the history of these counts. The retimed channel bit is updated on each channel-clock enable.

The run-length report is a valid-only stream. `run_vld` is high for one cycle per transition. There is no ready input and no back-pressure, because the loop cannot stall the disc. A consumer must take `run_len` and `run_viol` in the cycle that `run_vld` is high. Both values hold until the next report.

Top module: `efm_clk_rec`

## Requirements
- R1: While reset is low, `locked`, `run_vld` and `chan_ce` are 0. After reset, with a static input, `chan_ce` pulses exactly once every OSR (default 16) cycles. It is never high in two consecutive cycles.
- R2: When runs of n nominal channel periods (n = 3 to 11, each period being OSR cycles) repeat, or appear in a mixed sequence, each `run_vld` report settles to `run_len` = n.
- R3: A report whose length is below 3 or above 11 has `run_viol` = 1. A report inside 3 to 11 has `run_viol` = 0.
- R4: `locked` rises in the cycle of the 32nd consecutive in-band report. It stays 0 after the 31st.
- R5: `locked` falls in the cycle of the 4th consecutive violating report. It stays 1 after the 3rd.
- R6: With `fl_off` = 0, 11-period runs that last 183 cycles (about 4% slow) are still counted as 11 without violations once the loop settles, and the block ends locked.
- R7: With `fl_off` = 1, the frequency word stays frozen at its reset value. As a result, the same 183-cycle runs produce violating reports.
- R8: The frequency word always stays within nominal ± nominal/8.
- R9: In steady lock at the nominal rate, `chan_bit` presented with `chan_ce` equals the input level of the current run.
- R10: The run-length count saturates at 2^RL_W − 1 (31 by default). A 40-period run therefore reports 31 with a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock from the upstream multiplier stage |
| rst_n | input | 1 | Active-low reset: nominal frequency word, accumulator cleared, unlocked |
| efm_in | input | 1 | Asynchronous EFM playback level |
| fl_off | input | 1 | 1 holds the frequency path off, so only phase correction acts |
| chan_ce | output | 1 | One-cycle recovered channel-clock enable |
| chan_bit | output | 1 | Channel bit retimed at the last enable |
| run_vld | output | 1 | One-cycle strobe: a transition was seen and a run length is reported |
| run_len | output | RL_W | Whole channel periods between the last two transitions |
| run_viol | output | 1 | Reported run lies outside 3 to 11 |
| locked | output | 1 | Lock flag derived from consecutive run reports |

## Verification
The lock-edge properties take for granted that every rise or fall of `locked` arrives together with a run report. This holds only if transitions are seen at most once per cycle. The bench therefore holds each input level for at least two nominal periods (32 samples). The frozen-word property takes for granted that `fl_off` changes only at a clock edge. The bench drives it at the falling edge and changes it only while reset is low. The band and spacing properties assume the parameter choice keeps the top of the band far below half the accumulator range. The default parameters, which the bench uses, meet this.

// File: rtl/efm_clk_pkg.sv
package efm_clk_pkg;
  localparam int RUN_MIN = 3;
  localparam int RUN_MAX = 11;

  function automatic logic run_in_band(input int unsigned len);
    return (len >= RUN_MIN) && (len <= RUN_MAX);
  endfunction
endpackage

// File: rtl/efm_edge_sync.sv
module efm_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edge_p
);
  // pipe_q[SYNC_N-1:0] is the synchronizer; the extra flop gives the previous level
  logic [SYNC_N:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_N-1:0], din};
  end

  assign lvl    = pipe_q[SYNC_N-1];
  assign edge_p = pipe_q[SYNC_N] ^ pipe_q[SYNC_N-1];
endmodule

// File: rtl/efm_nco.sv
module efm_nco #(
  parameter int PH_W   = 16,
  parameter int FW_NOM = 4096,
  parameter int FW_MIN = 3584,
  parameter int FW_MAX = 4608,
  parameter int KP_SH  = 2,
  parameter int KF_SH  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_p,
  input  logic            fl_off,
  output logic            wrap,
  output logic [PH_W-1:0] fw
);
  localparam logic [PH_W-1:0]        HALF_V = {1'b1, {(PH_W-1){1'b0}}};
  localparam logic signed [PH_W+1:0] FW_LO  = $signed((PH_W+2)'(FW_MIN));
  localparam logic signed [PH_W+1:0] FW_HI  = $signed((PH_W+2)'(FW_MAX));

  logic [PH_W-1:0]        acc_q, fw_q, pcorr, fw_nx;
  logic [PH_W:0]          sum;
  logic signed [PH_W:0]   perr, fcorr;
  logic signed [PH_W+1:0] fw_try;

  assign sum   = {1'b0, acc_q} + {1'b0, fw_q};
  assign wrap  = sum[PH_W];
  // phase error: accumulator position at the transition relative to mid-period
  assign perr  = $signed({1'b0, acc_q} - {1'b0, HALF_V});
  assign pcorr = PH_W'(perr >>> KP_SH);
  assign fcorr = perr >>> KF_SH;

  always_comb begin
    fw_try = $signed({2'b00, fw_q}) - $signed({fcorr[PH_W], fcorr});
    if (fw_try < FW_LO)      fw_nx = PH_W'(FW_MIN);
    else if (fw_try > FW_HI) fw_nx = PH_W'(FW_MAX);
    else                     fw_nx = fw_try[PH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      fw_q  <= PH_W'(FW_NOM);
    end else begin
      acc_q <= edge_p ? (sum[PH_W-1:0] - pcorr) : sum[PH_W-1:0];
      if (edge_p && !fl_off) fw_q <= fw_nx;
    end
  end

  assign fw = fw_q;
endmodule

// File: rtl/efm_runlock.sv
module efm_runlock
  import efm_clk_pkg::*;
#(
  parameter int RL_W     = 5,
  parameter int LOCK_N   = 32,
  parameter int UNLOCK_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_p,
  input  logic            wrap,
  output logic            run_vld,
  output logic [RL_W-1:0] run_len,
  output logic            run_viol,
  output logic            locked
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(UNLOCK_N + 1);
  localparam logic [RL_W-1:0] CNT_MAX = '1;

  logic [RL_W-1:0] cnt_q;
  logic [GW-1:0]   good_q;
  logic [BW-1:0]   bad_q;
  logic            in_band;

  assign in_band = run_in_band(int'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      good_q   <= '0;
      bad_q    <= '0;
      run_vld  <= 1'b0;
      run_len  <= '0;
      run_viol <= 1'b0;
      locked   <= 1'b0;
    end else if (edge_p) begin
      run_vld  <= 1'b1;
      run_len  <= cnt_q;
      run_viol <= !in_band;
      cnt_q    <= wrap ? RL_W'(1) : '0;
      if (in_band) begin
        bad_q <= '0;
        if (good_q != GW'(LOCK_N))   good_q <= good_q + 1'b1;
        if (good_q == GW'(LOCK_N-1)) locked <= 1'b1;
      end else begin
        good_q <= '0;
        if (bad_q != BW'(UNLOCK_N))   bad_q  <= bad_q + 1'b1;
        if (bad_q == BW'(UNLOCK_N-1)) locked <= 1'b0;
      end
    end else begin
      run_vld <= 1'b0;
      if (wrap && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/efm_clk_rec.sv
module efm_clk_rec #(
  parameter int PH_W     = 16,
  parameter int OSR      = 16,
  parameter int BAND_SH  = 3,
  parameter int KP_SH    = 2,
  parameter int KF_SH    = 7,
  parameter int RL_W     = 5,
  parameter int LOCK_N   = 32,
  parameter int UNLOCK_N = 4,
  parameter int SYNC_N   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            efm_in,
  input  logic            fl_off,
  output logic            chan_ce,
  output logic            chan_bit,
  output logic            run_vld,
  output logic [RL_W-1:0] run_len,
  output logic            run_viol,
  output logic            locked
);
  localparam int FW_NOM  = (2 ** PH_W) / OSR;
  localparam int FW_BAND = FW_NOM >> BAND_SH;
  localparam int FW_MIN  = FW_NOM - FW_BAND;
  localparam int FW_MAX  = FW_NOM + FW_BAND;

  logic            lvl_w, edge_w, wrap_w;
  logic [PH_W-1:0] fw_w;

  efm_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(efm_in), .lvl(lvl_w), .edge_p(edge_w)
  );

  efm_nco #(
    .PH_W(PH_W), .FW_NOM(FW_NOM), .FW_MIN(FW_MIN), .FW_MAX(FW_MAX),
    .KP_SH(KP_SH), .KF_SH(KF_SH)
  ) u_nco (
    .clk(clk), .rst_n(rst_n), .edge_p(edge_w), .fl_off(fl_off),
    .wrap(wrap_w), .fw(fw_w)
  );

  efm_runlock #(.RL_W(RL_W), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_run (
    .clk(clk), .rst_n(rst_n), .edge_p(edge_w), .wrap(wrap_w),
    .run_vld(run_vld), .run_len(run_len), .run_viol(run_viol), .locked(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_ce  <= 1'b0;
      chan_bit <= 1'b0;
    end else begin
      chan_ce <= wrap_w;
      if (wrap_w) chan_bit <= lvl_w;
    end
  end
endmodule

// File: rtl/efm_clk_rec_chk.sv
module efm_clk_rec_chk #(
  parameter int PH_W   = 16,
  parameter int FW_MIN = 3584,
  parameter int FW_MAX = 4608
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fl_off,
  input logic            chan_ce,
  input logic            run_vld,
  input logic            run_viol,
  input logic            locked,
  input logic [PH_W-1:0] fw
);
  p_ce_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_ce |=> !chan_ce);

  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (run_vld && !run_viol));

  p_lock_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (run_vld && run_viol));

  p_fw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_off |=> $stable(fw));

  p_fw_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fw) >= FW_MIN) && (int'(fw) <= FW_MAX));
endmodule

bind efm_clk_rec efm_clk_rec_chk #(.PH_W(PH_W), .FW_MIN(FW_MIN), .FW_MAX(FW_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_off(fl_off), .chan_ce(chan_ce), .run_vld(run_vld),
  .run_viol(run_viol), .locked(locked), .fw(fw_w)
);

// File: tb/sim_efm_clk_rec.sv
module sim_efm_clk_rec;
  localparam int OSR = 16;
  localparam int RLW = 5;

  logic clk = 1'b0, rst_n = 1'b0, efm = 1'b0, fl_off = 1'b0;
  logic chan_ce, chan_bit, run_vld, run_viol, locked;
  logic [RLW-1:0] run_len;

  int n_chk = 0, n_bad = 0, lc = 0;
  bit done = 0, chk_bit = 0;
  int log_len [0:2047];
  bit log_viol[0:2047];
  bit log_lock[0:2047];

  always #5 clk = ~clk;

  efm_clk_rec u0 (
    .clk(clk), .rst_n(rst_n), .efm_in(efm), .fl_off(fl_off), .chan_ce(chan_ce),
    .chan_bit(chan_bit), .run_vld(run_vld), .run_len(run_len), .run_viol(run_viol),
    .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // toggle the level, then hold it for cyc samples
  task automatic run_cyc(input int cyc);
    efm = ~efm;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic do_reset(input bit fl);
    rst_n = 1'b0;
    fl_off = fl;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && run_vld && lc < 2048) begin
      log_len[lc]  = int'(run_len);
      log_viol[lc] = run_viol;
      log_lock[lc] = locked;
      lc++;
    end
    if (chk_bit && chan_ce)
      check(chan_bit == efm, "R9 chan_bit", int'(chan_bit), int'(efm));
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    int mark, gap, nviol;
    // R1: reset state and free-running enable spacing
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
    check(run_vld == 1'b0, "R1 run_vld in reset", int'(run_vld), 0);
    check(chan_ce == 1'b0, "R1 chan_ce in reset", int'(chan_ce), 0);
    rst_n = 1'b1;
    while (!chan_ce) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!chan_ce);
      check(gap == OSR, "R1 enable spacing", gap, OSR);
    end

    // R2/R9: sweep every legal run length at the nominal rate
    for (int n = 3; n <= 11; n++) begin
      for (int r = 0; r < 40; r++) begin
        if (r == 20) chk_bit = 1;
        run_cyc(n * OSR);
      end
      for (int i = lc - 8; i < lc; i++) begin
        check(log_len[i] == n, "R2 run length sweep", log_len[i], n);
        check(log_viol[i] == 1'b0, "R3 in-band no violation", int'(log_viol[i]), 0);
      end
    end
    chk_bit = 0;

    // R2: mixed sequence 3..11 repeated
    for (int rep = 0; rep < 5; rep++)
      for (int n = 3; n <= 11; n++) run_cyc(n * OSR);
    for (int k = 1; k <= 8; k++)
      check(log_len[lc-k] == 11 - k, "R2 mixed sequence", log_len[lc-k], 11 - k);
    check(locked == 1'b1, "R4 locked after legal runs", int'(locked), 1);

    // R3/R5/R4: four over-long runs drop lock, 32 legal runs regain it
    mark = lc;
    for (int k = 0; k < 4; k++) run_cyc(12 * OSR);
    for (int k = 0; k < 40; k++) run_cyc(4 * OSR);
    for (int k = 1; k <= 4; k++) begin
      check(log_len[mark+k] == 12, "R3 long run length", log_len[mark+k], 12);
      check(log_viol[mark+k] == 1'b1, "R3 long run flagged", int'(log_viol[mark+k]), 1);
    end
    check(log_lock[mark+3] == 1'b1, "R5 held after 3 violations", int'(log_lock[mark+3]), 1);
    check(log_lock[mark+4] == 1'b0, "R5 dropped on 4th violation", int'(log_lock[mark+4]), 0);
    check(log_lock[mark+35] == 1'b0, "R4 not yet after 31 good", int'(log_lock[mark+35]), 0);
    check(log_lock[mark+36] == 1'b1, "R4 locked on 32nd good", int'(log_lock[mark+36]), 1);

    // R3/R10: short run and saturated long run
    mark = lc;
    run_cyc(2 * OSR);
    run_cyc(40 * OSR);
    for (int k = 0; k < 3; k++) run_cyc(4 * OSR);
    check(log_len[mark+1] == 2, "R3 short run length", log_len[mark+1], 2);
    check(log_viol[mark+1] == 1'b1, "R3 short run flagged", int'(log_viol[mark+1]), 1);
    check(log_len[mark+2] == 31, "R10 saturated length", log_len[mark+2], 31);
    check(log_viol[mark+2] == 1'b1, "R10 saturated flagged", int'(log_viol[mark+2]), 1);

    // R6: frequency path follows a slow disc
    do_reset(1'b0);
    for (int k = 0; k < 20; k++) run_cyc(4 * OSR);
    for (int k = 0; k < 40; k++) run_cyc(183);
    for (int i = lc - 20; i < lc; i++) begin
      check(log_len[i] == 11, "R6 tracked length", log_len[i], 11);
      check(log_viol[i] == 1'b0, "R6 no violation", int'(log_viol[i]), 0);
    end
    check(locked == 1'b1, "R6 locked while tracking", int'(locked), 1);

    // R7: same stimulus with the frequency path held off
    do_reset(1'b1);
    for (int k = 0; k < 20; k++) run_cyc(4 * OSR);
    mark = lc;
    for (int k = 0; k < 40; k++) run_cyc(183);
    nviol = 0;
    for (int i = mark + 1; i < lc; i++) nviol += int'(log_viol[i]);
    check(nviol > 0, "R7 violations without frequency path", nviol, 1);

    done = 1;
    finish_up();
  end
endmodule